// File: doc/BRIEF.md
# Multi-Port Register File with Same-Cycle Forwarding

This block is a 32-word by 32-bit register file for a DSP datapath. It has ten read ports and six write ports, and all of them work in the same clock cycle. Each write port has an address, a data word and an enable. The word is stored on the rising clock edge. Each read port turns an address into a data word through combinational logic.

When a read address matches an enabled write in the same cycle, the incoming write data goes straight to the read output through a forwarding path. The read therefore never sees the old contents. If several writers aim at one word, the writer with the highest index wins, both in the array and on the forwarding path.

Addresses pass through a two-stage decoder. The first stage predecodes groups of address bits into one-hot lines. The second stage combines those lines into a one-hot word select. Words are kept inverted inside the array and are inverted again on the read path, so the ports always show true data. The read outputs are combinational, not registered, because the design must forward a write to a read within one cycle.

Top module: `rfb_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every word. In the cycle after reset, with no write enabled, every read port returns 0x00000000.
- R2: A word written on a rising edge (enable high, reset low) is returned by a read of that address in every later cycle until it is overwritten.
- R3: Each read port returns exactly the word at its own 5-bit address. The address is decoded as a 2-bit low group and a 3-bit high group, combined into one of 32 word selects.
- R4: When a read address equals the address of an enabled write in the same cycle, the read returns that cycle's write data.
- R5: When several enabled write ports target one address in a cycle, the highest-numbered port's data is both forwarded and stored.
- R6: A read whose address matches no enabled write returns the value stored at the previous edge. It stays unchanged while no writes occur.
- R7: All ten read ports and all six write ports operate independently in the same cycle, including reads of distinct addresses.
- R8: Stored data is returned in true polarity for every bit pattern, including all-ones, all-zeros and alternating patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the array updates on the rising edge |
| rst | input | 1 | Synchronous active-high clear of all words |
| wr_en | input | 6 | Write enable per write port |
| wr_addr | input | 6x5 | Word address per write port |
| wr_data | input | 6x32 | Write data per write port |
| rd_addr | input | 10x5 | Word address per read port |
| rd_data | output | 10x32 | Read data per read port (combinational) |

## Verification
A corrupted stored word, a wrong word select or a missed inversion shows up on the very next read of that address. Since every port is compared in every cycle, the fault appears in the first cycle any port reads that entry. A forwarding or priority fault shows up in the same cycle as the colliding write. A storage-priority fault shows up one cycle later, when the entry is read back without a write. Random traffic over a narrow address range makes collisions and same-cycle read-after-write frequent, so these faults surface within a few cycles.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int unsigned RFB_DW = 32;
  localparam int unsigned RFB_AW = 5;
  localparam int unsigned RFB_NR = 10;
  localparam int unsigned RFB_NW = 6;
  localparam int unsigned RFB_DEPTH = 1 << RFB_AW;
endpackage

// File: rtl/rfb_predecode.sv
module rfb_predecode #(
  parameter int unsigned AW = rfb_pkg::RFB_AW
) (
  input  logic [AW-1:0]      addr,
  output logic [(1<<AW)-1:0] sel
);
  localparam int unsigned LO_W  = AW / 2;
  localparam int unsigned HI_W  = AW - LO_W;
  localparam int unsigned LO_N  = 1 << LO_W;
  localparam int unsigned HI_N  = 1 << HI_W;
  localparam int unsigned DEPTH = 1 << AW;

  logic [LO_N-1:0] lo_line;
  logic [HI_N-1:0] hi_line;

  // stage one: one-hot lines per address bit group
  always_comb begin
    for (int i = 0; i < LO_N; i++)
      lo_line[i] = (addr[LO_W-1:0] == LO_W'(i));
    for (int j = 0; j < HI_N; j++)
      hi_line[j] = (addr[AW-1:LO_W] == HI_W'(j));
  end

  // stage two: combine group lines into a word select
  for (genvar e = 0; e < DEPTH; e++) begin : g_word
    assign sel[e] = lo_line[e % LO_N] & hi_line[e / LO_N];
  end
endmodule

// File: rtl/rfb_readport.sv
module rfb_readport #(
  parameter int unsigned DW    = rfb_pkg::RFB_DW,
  parameter int unsigned AW    = rfb_pkg::RFB_AW,
  parameter int unsigned NW    = rfb_pkg::RFB_NW,
  parameter int unsigned DEPTH = 1 << AW
) (
  input  logic [DEPTH-1:0]          word_sel,
  input  logic [DEPTH-1:0][DW-1:0]  store_n,
  input  logic [AW-1:0]             addr,
  input  logic [NW-1:0]             wr_en,
  input  logic [NW-1:0][AW-1:0]     wr_addr,
  input  logic [NW-1:0][DW-1:0]     wr_data,
  output logic [DW-1:0]             data
);
  logic [DW-1:0] picked_n;
  logic [DW-1:0] fwd_val;
  logic          fwd_hit;

  // AND-OR selection of the inverted word
  always_comb begin
    picked_n = '0;
    for (int e = 0; e < DEPTH; e++)
      picked_n |= store_n[e] & {DW{word_sel[e]}};
  end

  // forwarding: later (higher) write ports override earlier ones
  always_comb begin
    fwd_hit = 1'b0;
    fwd_val = '0;
    for (int w = 0; w < NW; w++) begin
      if (wr_en[w] && (wr_addr[w] == addr)) begin
        fwd_hit = 1'b1;
        fwd_val = wr_data[w];
      end
    end
  end

  assign data = fwd_hit ? fwd_val : ~picked_n;
endmodule

// File: rtl/rfb_regfile.sv
module rfb_regfile #(
  parameter int unsigned DW = rfb_pkg::RFB_DW,
  parameter int unsigned AW = rfb_pkg::RFB_AW,
  parameter int unsigned NR = rfb_pkg::RFB_NR,
  parameter int unsigned NW = rfb_pkg::RFB_NW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NW-1:0]         wr_en,
  input  logic [NW-1:0][AW-1:0] wr_addr,
  input  logic [NW-1:0][DW-1:0] wr_data,
  input  logic [NR-1:0][AW-1:0] rd_addr,
  output logic [NR-1:0][DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] store_n;
  logic [DEPTH-1:0][DW-1:0] store_n_nxt;
  logic [NW-1:0][DEPTH-1:0] wsel;
  logic [NR-1:0][DEPTH-1:0] rsel;

  for (genvar w = 0; w < NW; w++) begin : g_wdec
    rfb_predecode #(.AW(AW)) u_wdec (.addr(wr_addr[w]), .sel(wsel[w]));
  end

  // next inverted word per entry; highest enabled port wins
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_comb begin
      store_n_nxt[e] = store_n[e];
      for (int w = 0; w < NW; w++)
        if (wr_en[w] && wsel[w][e]) store_n_nxt[e] = ~wr_data[w];
    end
  end

  // cleared storage is all ones in inverted form
  always_ff @(posedge clk) begin
    if (rst) store_n <= '1;
    else     store_n <= store_n_nxt;
  end

  for (genvar r = 0; r < NR; r++) begin : g_read
    rfb_predecode #(.AW(AW)) u_rdec (.addr(rd_addr[r]), .sel(rsel[r]));

    rfb_readport #(.DW(DW), .AW(AW), .NW(NW), .DEPTH(DEPTH)) u_port (
      .word_sel (rsel[r]),
      .store_n  (store_n),
      .addr     (rd_addr[r]),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .data     (rd_data[r])
    );

    // R3: decoder yields exactly one word select
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (rst)
      $countones(rsel[r]) == 1);

    // R5: top-priority writer is always what gets forwarded
    p_fwd_top_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_en[NW-1] && wr_addr[NW-1] == rd_addr[r]) |-> rd_data[r] == wr_data[NW-1]);

    // R2: top-priority write is read back next cycle when not overwritten
    p_store_r2: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en[NW-1]) && !$past(rst) && wr_en == '0 &&
       rd_addr[r] == $past(wr_addr[NW-1])) |-> rd_data[r] == $past(wr_data[NW-1]));

    // R6: no writes, stable address -> stable data
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en == '0 && $past(wr_en) == '0 && !$past(rst) && $stable(rd_addr[r]))
      |-> $stable(rd_data[r]));

    // R1: after reset, reads are zero without writes
    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && wr_en == '0) |-> rd_data[r] == '0);
  end
endmodule

// File: tb/rfb_regfile_tb_top.sv
module rfb_regfile_tb_top;
  localparam int DW = 32, AW = 5, NR = 10, NW = 6, DEPTH = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]         wr_en = '0;
  logic [NW-1:0][AW-1:0] wr_addr = '0;
  logic [NW-1:0][DW-1:0] wr_data = '0;
  logic [NR-1:0][AW-1:0] rd_addr = '0;
  logic [NR-1:0][DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #10 clk = ~clk;

  rfb_regfile dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
                     .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  // one cycle: drive at negedge, compare 5 ns later, advance model
  task automatic cycle(input string tag);
    logic [DW-1:0] exp;
    int hits;
    #5;
    if (!rst) begin
      for (int r = 0; r < NR; r++) begin
        exp = ref_mem[rd_addr[r]];
        hits = 0;
        for (int w = 0; w < NW; w++)
          if (wr_en[w] && wr_addr[w] == rd_addr[r]) begin exp = wr_data[w]; hits++; end
        checks++;
        if (rd_data[r] !== exp) begin
          errors++;
          $display("FAIL %s port %0d addr %0d: actual %h expected %h",
                   hits > 1 ? "R5" : (hits == 1 ? "R4" : tag), r, rd_addr[r], rd_data[r], exp);
        end
      end
    end
    if (rst) for (int e = 0; e < DEPTH; e++) ref_mem[e] = '0;
    else for (int w = 0; w < NW; w++) if (wr_en[w]) ref_mem[wr_addr[w]] = wr_data[w];
    @(negedge clk);
  endtask

  task automatic idle_reads(input int base);
    wr_en = '0;
    for (int r = 0; r < NR; r++) rd_addr[r] = AW'((base + r * 3) % DEPTH);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) cycle("R1");
    rst = 1'b0;
    // R1: all words read zero after reset
    for (int b = 0; b < DEPTH; b += 8) begin idle_reads(b); cycle("R1"); end

    // R2/R8: fill every word with patterns, read back later
    for (int b = 0; b < DEPTH; b += NW) begin
      idle_reads(0);
      for (int w = 0; w < NW; w++) begin
        wr_en[w] = (b + w) < DEPTH;
        wr_addr[w] = AW'((b + w) % DEPTH);
        case ((b + w) % 4)
          0: wr_data[w] = '1;
          1: wr_data[w] = '0;
          2: wr_data[w] = 32'hAAAA5555;
          default: wr_data[w] = 32'h01234567 ^ DW'(b + w);
        endcase
      end
      for (int r = 0; r < NR; r++) rd_addr[r] = AW'((b + 20 + r) % DEPTH);
      cycle("R8");
    end
    // R3/R7: distinct addresses on all read ports
    for (int b = 0; b < DEPTH; b++) begin idle_reads(b); cycle("R7"); end
    // R2: read back unchanged across idle cycles
    for (int b = 0; b < 4; b++) begin idle_reads(b * 5); cycle("R2"); end
    repeat (3) cycle("R6");

    // R5: all writers on one address, then read back stored winner
    wr_en = '1;
    for (int w = 0; w < NW; w++) begin wr_addr[w] = 5'd7; wr_data[w] = 32'hC0DE0000 + DW'(w); end
    for (int r = 0; r < NR; r++) rd_addr[r] = AW'(r);
    cycle("R5");
    idle_reads(7);
    rd_addr[0] = 5'd7;
    cycle("R5");
    // R5: lower-numbered enabled ports only (top port off)
    wr_en = 6'b001011;
    for (int w = 0; w < NW; w++) begin wr_addr[w] = 5'd9; wr_data[w] = 32'h9000 + DW'(w); end
    rd_addr[0] = 5'd9;
    cycle("R5");
    idle_reads(9);
    rd_addr[0] = 5'd9;
    cycle("R5");

    // random traffic with narrow address range for collisions
    for (int n = 0; n < 3000; n++) begin
      int span;
      span = (n % 3 == 0) ? DEPTH : 4;
      for (int w = 0; w < NW; w++) begin
        wr_en[w] = ($urandom_range(0, 2) != 0);
        wr_addr[w] = AW'($urandom_range(0, span - 1));
        wr_data[w] = $urandom;
      end
      for (int r = 0; r < NR; r++) rd_addr[r] = AW'($urandom_range(0, span - 1));
      cycle("R6");
    end

    // R1: reset in the middle of traffic
    rst = 1'b1;
    wr_en = '1;
    cycle("R1");
    rst = 1'b0;
    for (int b = 0; b < DEPTH; b += 8) begin idle_reads(b + 1); cycle("R1"); end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule